// File: doc/BRIEF.md
# Precondition Priority Dispatch Unit

This unit sits in front of the opcode dispatch of a microcoded sequencer. Seven global conditions can raise requests: a soft reset request, a stack-overflow trap, a reference-count trap, two interrupt levels, an output interrupt and an invalid-opcode indication. Each request is latched and stays pending until the microcode that services it pulses that source's clear input. At every opcode boundary the unit chooses the most urgent eligible request. It then presents a dispatch address that selects that request's handler entry in the upper half of the 256-entry dispatch space.

When no eligible request is pending, the opcode presented at the boundary passes through unchanged as the dispatch address. The three interrupt sources are gated by a global interrupt enable. The unit does not clear a request when it dispatches it, because the handler clears it.

Control is a two-state machine. In `S_IDLE` the unit waits, `disp_valid_o` is low and the address is held. On a boundary strobe it takes the `boundary` transition to `S_ISSUE`, which asserts `disp_valid_o` for that cycle. A further strobe while in `S_ISSUE` is the `reissue` transition, which stays in `S_ISSUE` with a freshly sampled address. With no strobe, the `retire` transition returns to `S_IDLE`.

Top module: `pdu_dispatch`

## Requirements
- R1: After `rst_n` is released, `disp_valid_o` is 0, `disp_addr_o` is 0 and no request is pending.
- R2: A request raised by a one-cycle pulse on its bit of `cond_set_i` stays pending until that bit of `cond_clr_i` is pulsed. Raising and clearing the same bit in the same cycle leaves it pending.
- R3: A pulse on a bit of `cond_clr_i` removes only that request. Clearing a bit that is not pending has no effect on the dispatch address.
- R4: Bit positions of `cond_set_i` and `cond_clr_i` are: 0 reset request, 1 stack overflow, 2 reference count, 3 interrupt 1, 4 interrupt 2, 5 output interrupt, 6 invalid opcode. Priority follows the bit index, so bit 0 is highest and bit 6 (invalid opcode) is lowest.
- R5: The entry address for the chosen request at bit k is 128 + 2^k. The resulting addresses are 129, 130, 132, 136, 144, 160 and 192.
- R6: When `irq_en_i` is 0 at the boundary, bits 3, 4 and 5 are not eligible. Bits 0, 1, 2 and 6 are never masked.
- R7: When no eligible request is pending at a boundary, `disp_addr_o` equals the `opcode_i` value sampled at that boundary.
- R8: `disp_valid_o` is 1 in exactly the cycle after each cycle in which `op_bound_i` is 1. `disp_addr_o` changes only after a boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cond_set_i | input | 7 | Per-source request pulses (bit map in R4) |
| cond_clr_i | input | 7 | Per-source clear pulses |
| irq_en_i | input | 1 | Global interrupt enable for bits 3 to 5 |
| op_bound_i | input | 1 | Opcode-boundary strobe |
| opcode_i | input | 8 | Normal opcode for pass-through |
| disp_valid_o | output | 1 | Dispatch address valid, one cycle per boundary |
| disp_addr_o | output | 8 | Registered dispatch address |

## Verification
Every one of the 128 pending-request patterns is raised, then dispatched once with the interrupt enable high and once with it low. This separates priority order, entry encoding and masking, and it covers the empty pattern, which must yield the opcode. Further sequences hold a request over idle cycles and then collide a set with a clear. They also clear an absent request and strobe two boundaries back to back. Together these tell stickiness, set-over-clear precedence, clear isolation and re-sampling apart from one another.

// File: rtl/pdu_pkg.sv
package pdu_pkg;
    localparam int NSRC = 7;
    localparam int OPW  = 8;

    // Interrupt-class sources gated by the global enable: bits 3, 4, 5
    localparam logic [NSRC-1:0] MASKABLE = 7'b0111000;

    typedef enum logic {
        S_IDLE  = 1'b0,
        S_ISSUE = 1'b1
    } pdu_state_e;
endpackage

// File: rtl/pdu_pend_reg.sv
module pdu_pend_reg #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    output logic [N-1:0] pend_o
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend_o[i] <= 1'b0;
                else if (set_i[i])
                    pend_o[i] <= 1'b1;
                else if (clr_i[i])
                    pend_o[i] <= 1'b0;
            end

            // R2
            hold_until_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (pend_o[i] && !clr_i[i]) |=> pend_o[i]);

            // R2
            set_beats_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
                set_i[i] |=> pend_o[i]);

            // R3
            clear_removes_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (clr_i[i] && !set_i[i]) |=> !pend_o[i]);
        end
    endgenerate
endmodule

// File: rtl/pdu_prio_enc.sv
module pdu_prio_enc #(
    parameter int              N        = 7,
    parameter int              OPW      = 8,
    parameter logic [N-1:0]    MASKABLE = '0
) (
    input  logic [N-1:0]   pend_i,
    input  logic           irq_en_i,
    output logic           hit_o,
    output logic [OPW-1:0] entry_o
);
    localparam logic [OPW-1:0] BASE = OPW'(1) << (OPW - 1);

    logic [N-1:0] elig;
    logic [N-1:0] grant;

    always_comb begin
        elig  = irq_en_i ? pend_i : (pend_i & ~MASKABLE);
        grant = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
            end
        end
        hit_o   = |elig;
        entry_o = BASE | OPW'(grant);
    end
endmodule

// File: rtl/pdu_dispatch.sv
module pdu_dispatch
    import pdu_pkg::*;
#(
    parameter int N   = NSRC,
    parameter int OW  = OPW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cond_set_i,
    input  logic [N-1:0]  cond_clr_i,
    input  logic          irq_en_i,
    input  logic          op_bound_i,
    input  logic [OW-1:0] opcode_i,
    output logic          disp_valid_o,
    output logic [OW-1:0] disp_addr_o
);
    localparam logic [OW-1:0] RST_ENTRY = (OW'(1) << (OW - 1)) | OW'(1);

    logic [N-1:0]  pend;
    logic          hit;
    logic [OW-1:0] entry;
    pdu_state_e    state_q, state_d;

    pdu_pend_reg #(.N(N)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (cond_set_i),
        .clr_i  (cond_clr_i),
        .pend_o (pend)
    );

    pdu_prio_enc #(.N(N), .OPW(OW), .MASKABLE(MASKABLE[N-1:0])) u_enc (
        .pend_i   (pend),
        .irq_en_i (irq_en_i),
        .hit_o    (hit),
        .entry_o  (entry)
    );

    // next-state: boundary / reissue / retire
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (op_bound_i)  state_d = S_ISSUE;
            S_ISSUE: if (!op_bound_i) state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    // outputs
    always_ff @(posedge clk) begin
        if (!rst_n)
            disp_addr_o <= '0;
        else if (op_bound_i)
            disp_addr_o <= hit ? entry : opcode_i;
    end

    always_comb begin
        unique case (state_q)
            S_IDLE:  disp_valid_o = 1'b0;
            S_ISSUE: disp_valid_o = 1'b1;
        endcase
    end

    // R8
    valid_after_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_bound_i |=> disp_valid_o);

    // R8
    no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_bound_i |=> !disp_valid_o);

    // R8
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_bound_i |=> $stable(disp_addr_o));

    // R7
    passthrough_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bound_i && pend == '0) |=> disp_addr_o == $past(opcode_i));

    // R6
    reset_req_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_bound_i && pend[0]) |=> disp_addr_o == RST_ENTRY);
endmodule

// File: tb/pdu_dispatch_bench.sv
module pdu_dispatch_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] cond_set_i = '0;
    logic [6:0] cond_clr_i = '0;
    logic       irq_en_i = 1'b0;
    logic       op_bound_i = 1'b0;
    logic [7:0] opcode_i = '0;
    logic       disp_valid_o;
    logic [7:0] disp_addr_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pdu_dispatch u_pdu_dispatch (
        .clk          (clk),
        .rst_n        (rst_n),
        .cond_set_i   (cond_set_i),
        .cond_clr_i   (cond_clr_i),
        .irq_en_i     (irq_en_i),
        .op_bound_i   (op_bound_i),
        .opcode_i     (opcode_i),
        .disp_valid_o (disp_valid_o),
        .disp_addr_o  (disp_addr_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4 R5 R6 R7: expected dispatch address from the requirements
    function automatic int exp_addr(int pat, bit en, int op);
        int m = en ? pat : (pat & ~'h38);
        for (int k = 0; k < 7; k++)
            if (((m >> k) & 1) != 0) return 128 + (1 << k);
        return op;
    endfunction

    task automatic step();
        @(negedge clk);
    endtask

    task automatic dispatch(bit en, int op);
        op_bound_i = 1'b1;
        irq_en_i   = en;
        opcode_i   = 8'(op);
        step();
        op_bound_i = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        step();
        step();
        rst_n = 1'b1;
        step();
        // R1
        check("R1 valid", int'(disp_valid_o), 0);
        check("R1 addr", int'(disp_addr_o), 0);
        dispatch(1'b1, 8'h5A);
        check("R1 nothing pending", int'(disp_addr_o), 'h5A);
        step();

        // R4 R5 R6 R7: sweep all patterns, both enables
        for (int pat = 0; pat < 128; pat++) begin
            for (int en = 0; en < 2; en++) begin
                int op = (pat * 37 + en * 11 + 3) & 8'hFF;
                cond_set_i = 7'(pat);
                step();
                cond_set_i = '0;
                dispatch(en[0], op);
                check("R8 valid after bound", int'(disp_valid_o), 1);
                check("R4 R5 R6 R7 sweep", int'(disp_addr_o), exp_addr(pat, en[0], op));
                cond_clr_i = '1;
                step();
                cond_clr_i = '0;
                check("R8 valid drops", int'(disp_valid_o), 0);
                check("R8 addr held", int'(disp_addr_o), exp_addr(pat, en[0], op));
            end
        end

        // R2: sticky over idle cycles and repeated dispatches
        cond_set_i = 7'b0010000;
        step();
        cond_set_i = '0;
        repeat (5) step();
        dispatch(1'b1, 8'h11);
        check("R2 held", int'(disp_addr_o), 144);
        step();
        dispatch(1'b1, 8'h12);
        check("R2 not auto-cleared", int'(disp_addr_o), 144);

        // R2: set and clear same cycle leaves pending
        cond_clr_i = 7'b0010000;
        cond_set_i = 7'b0000100;
        step();
        cond_clr_i = 7'b0000100;
        cond_set_i = 7'b0000100;
        step();
        cond_clr_i = '0;
        cond_set_i = '0;
        dispatch(1'b1, 8'h13);
        check("R2 set beats clear", int'(disp_addr_o), 132);

        // R3: clearing an absent bit changes nothing; clear removes only its bit
        cond_clr_i = 7'b1000001;
        step();
        cond_clr_i = '0;
        dispatch(1'b1, 8'h14);
        check("R3 absent clear", int'(disp_addr_o), 132);
        cond_set_i = 7'b1000000;
        step();
        cond_set_i = '0;
        cond_clr_i = 7'b0000100;
        step();
        cond_clr_i = '0;
        dispatch(1'b1, 8'h15);
        check("R3 clear isolation", int'(disp_addr_o), 192);
        cond_clr_i = 7'b1000000;
        step();
        cond_clr_i = '0;
        dispatch(1'b1, 8'h16);
        check("R3 all cleared", int'(disp_addr_o), 'h16);

        // R8: back-to-back boundaries resample
        op_bound_i = 1'b1;
        opcode_i   = 8'h21;
        step();
        opcode_i   = 8'h22;
        step();
        op_bound_i = 1'b0;
        check("R8 reissue valid", int'(disp_valid_o), 1);
        check("R8 reissue addr", int'(disp_addr_o), 'h22);
        step();
        check("R8 retire", int'(disp_valid_o), 0);

        finish_run();
    end
endmodule